// File: doc/BRIEF.md
# Compartment Access Filter with Hardware Semaphore

This block guards one bus resource channel. Every bus request carries the compartment ID of its requester. The block answers with a combinational grant or deny, based on its current register state. There are two routes to a grant. The first is a single static owner ID held in the configuration register. The second is a hardware mutex that only compartments on a whitelist may use. The mutex records which compartment currently holds it.

A plain register port sets up the block and carries the semaphore traffic. Address 0 selects the configuration register and address 1 selects the semaphore register. Each write to the semaphore register arrives together with the writer's compartment ID. Writing 1 to the mutex bit is an acquire attempt, and writing 0 is a release. Reading the register shows whether the semaphore is free and, if not, who holds it. The number of supported compartments `NUM_CID` sets the width of the ID fields and of the whitelist.

Top module: `comp_access_filter`

## Requirements
- R1: After reset both registers read 0 and every compartment ID is granted.
- R2: While the filter-enable bit (config bit 0) is 0, every compartment ID is granted, whatever the other fields hold.
- R3: While filtering is on, a requester whose ID equals the static ID field (config bits [6:4]) is granted.
- R4: While filtering and the semaphore-enable bit (config bit 1) are on and the mutex is free, a requester whose whitelist bit (config bit 16+ID) is 1 is granted.
- R5: While the mutex is held, a whitelisted non-static requester is granted only if it is the recorded owner.
- R6: A request matching none of R2 to R5 is denied, including whitelisted IDs while semaphore-enable is 0.
- R7: A write of 1 to the mutex bit (semaphore bit 0) by an allowed writer while the mutex is free makes the semaphore read mutex 1 with the writer's ID at bits [6:4].
- R8: An acquire attempt leaves the semaphore unchanged if semaphore-enable is 0, if the writer's whitelist bit is 0, or if the mutex is held.
- R9: A write of 0 to the mutex bit by the current owner frees the semaphore, which then reads 0. A release by any other compartment is ignored.
- R10: Config bits outside filter-enable, semaphore-enable, the static ID and the whitelist are not stored and read 0.
- R11: Register writes change the grant from the clock edge that stores them onward. The grant follows a change of requester ID within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects config, 1 selects semaphore |
| reg_wdata_i | input | 32 | Write data |
| reg_wid_i | input | ID_W | Compartment ID of the register writer |
| reg_rdata_o | output | 32 | Read data of the selected register |
| acc_cid_i | input | ID_W | Compartment ID of the bus requester |
| acc_grant_o | output | 1 | 1 grants the request, 0 denies it |

## Verification
A corrupted owner field or a stuck mutex bit shows up on the semaphore readback as soon as the next read. It also shows up on the grant port as soon as a whitelisted ID other than the true owner is presented, because that ID gets the wrong grant value in the same cycle. A whitelist or static-ID field stored at the wrong bits shows up as a wrong config readback. It also shows up as a grant or deny for the wrong compartment in the cycle after the write. The bench therefore reads back the semaphore after every ownership step. It probes the grant with the owner, a competing whitelisted ID, the static ID and an outsider.

// File: rtl/cfilt_pkg.sv
package cfilt_pkg;
  localparam int DATA_W    = 32;
  localparam int MAX_ID_W  = 3;
  localparam int FEN_BIT   = 0;
  localparam int SEMEN_BIT = 1;
  localparam int ID_LSB    = 4;
  localparam int WL_LSB    = 16;
  localparam int MUTEX_BIT = 0;

  typedef enum logic {
    SEL_CFG = 1'b0,
    SEL_SEM = 1'b1
  } reg_sel_e;

  function automatic int id_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cfilt_cfg_regs.sv
module cfilt_cfg_regs
  import cfilt_pkg::*;
#(
  parameter int NUM_CID = 8,
  parameter int ID_W    = id_width(NUM_CID)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              fen_o,
  output logic              sem_en_o,
  output logic [ID_W-1:0]   scid_o,
  output logic [NUM_CID-1:0] wl_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic               fen_q, sem_en_q;
  logic [ID_W-1:0]    scid_q;
  logic [NUM_CID-1:0] wl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q    <= 1'b0;
      sem_en_q <= 1'b0;
      scid_q   <= '0;
      wl_q     <= '0;
    end else if (we_i) begin
      fen_q    <= wdata_i[FEN_BIT];
      sem_en_q <= wdata_i[SEMEN_BIT];
      scid_q   <= wdata_i[ID_LSB +: ID_W];
      wl_q     <= wdata_i[WL_LSB +: NUM_CID];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[FEN_BIT]            = fen_q;
    rdata_o[SEMEN_BIT]          = sem_en_q;
    rdata_o[ID_LSB +: ID_W]     = scid_q;
    rdata_o[WL_LSB +: NUM_CID]  = wl_q;
  end

  assign fen_o    = fen_q;
  assign sem_en_o = sem_en_q;
  assign scid_o   = scid_q;
  assign wl_o     = wl_q;

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/cfilt_sema.sv
module cfilt_sema
  import cfilt_pkg::*;
#(
  parameter int NUM_CID = 8,
  parameter int ID_W    = id_width(NUM_CID)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [ID_W-1:0]    wid_i,
  input  logic               sem_en_i,
  input  logic [NUM_CID-1:0] wl_i,
  output logic               mutex_o,
  output logic [ID_W-1:0]    owner_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic            mutex_q;
  logic [ID_W-1:0] owner_q;
  logic            wr_listed, take, drop;

  always_comb begin
    wr_listed = 1'b0;
    for (int i = 0; i < NUM_CID; i++)
      if (wid_i == ID_W'(i)) wr_listed = wl_i[i];
  end

  assign take = we_i &&  wdata_i[MUTEX_BIT] && !mutex_q && sem_en_i && wr_listed;
  assign drop = we_i && !wdata_i[MUTEX_BIT] &&  mutex_q && (owner_q == wid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mutex_q <= 1'b0;
      owner_q <= '0;
    end else if (take) begin
      mutex_q <= 1'b1;
      owner_q <= wid_i;
    end else if (drop) begin
      mutex_q <= 1'b0;
      owner_q <= '0;
    end
  end

  always_comb begin
    rdata_o                 = '0;
    rdata_o[MUTEX_BIT]      = mutex_q;
    rdata_o[ID_LSB +: ID_W] = owner_q;
  end

  assign mutex_o = mutex_q;
  assign owner_o = owner_q;

  // R7
  acquire_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[MUTEX_BIT] && !mutex_o && sem_en_i && wl_i[wid_i])
      |=> (mutex_o && owner_o == $past(wid_i)));
  // R8
  acquire_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[MUTEX_BIT] && mutex_o) |=> ($stable(mutex_o) && $stable(owner_o)));
  // R8
  acquire_barred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[MUTEX_BIT] && (!sem_en_i || !wl_i[wid_i]))
      |=> ($stable(mutex_o) && $stable(owner_o)));
  // R9
  foreign_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[MUTEX_BIT] && owner_o != wid_i) |=> ($stable(mutex_o) && $stable(owner_o)));
  // R9
  free_owner_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mutex_o |-> (owner_o == '0));
endmodule

// File: rtl/cfilt_grant.sv
module cfilt_grant
  import cfilt_pkg::*;
#(
  parameter int NUM_CID = 8,
  parameter int ID_W    = id_width(NUM_CID)
) (
  input  logic               fen_i,
  input  logic               sem_en_i,
  input  logic [ID_W-1:0]    scid_i,
  input  logic [NUM_CID-1:0] wl_i,
  input  logic               mutex_i,
  input  logic [ID_W-1:0]    owner_i,
  input  logic [ID_W-1:0]    cid_i,
  output logic               grant_o
);
  logic listed, static_hit, sem_hit;

  always_comb begin
    listed = 1'b0;
    for (int i = 0; i < NUM_CID; i++)
      if (cid_i == ID_W'(i)) listed = wl_i[i];
  end

  assign static_hit = (cid_i == scid_i);
  assign sem_hit    = sem_en_i && listed && (!mutex_i || owner_i == cid_i);
  assign grant_o    = !fen_i || static_hit || sem_hit;
endmodule

// File: rtl/comp_access_filter.sv
module comp_access_filter
  import cfilt_pkg::*;
#(
  parameter int NUM_CID = 8,
  parameter int ID_W    = id_width(NUM_CID)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ID_W-1:0]   reg_wid_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ID_W-1:0]   acc_cid_i,
  output logic              acc_grant_o
);
  reg_sel_e           sel;
  logic               fen, sem_en, mutex;
  logic [ID_W-1:0]    scid, owner;
  logic [NUM_CID-1:0] wl;
  logic [DATA_W-1:0]  cfg_rdata, sem_rdata;

  initial assert (NUM_CID >= 1 && ID_W <= MAX_ID_W && NUM_CID <= (1 << ID_W));

  assign sel = reg_sel_e'(reg_addr_i);

  cfilt_cfg_regs #(.NUM_CID(NUM_CID), .ID_W(ID_W)) i_cfg (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i && sel == SEL_CFG),
    .wdata_i  (reg_wdata_i),
    .fen_o    (fen),
    .sem_en_o (sem_en),
    .scid_o   (scid),
    .wl_o     (wl),
    .rdata_o  (cfg_rdata)
  );

  cfilt_sema #(.NUM_CID(NUM_CID), .ID_W(ID_W)) i_sema (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i && sel == SEL_SEM),
    .wdata_i  (reg_wdata_i),
    .wid_i    (reg_wid_i),
    .sem_en_i (sem_en),
    .wl_i     (wl),
    .mutex_o  (mutex),
    .owner_o  (owner),
    .rdata_o  (sem_rdata)
  );

  cfilt_grant #(.NUM_CID(NUM_CID), .ID_W(ID_W)) i_grant (
    .fen_i    (fen),
    .sem_en_i (sem_en),
    .scid_i   (scid),
    .wl_i     (wl),
    .mutex_i  (mutex),
    .owner_i  (owner),
    .cid_i    (acc_cid_i),
    .grant_o  (acc_grant_o)
  );

  assign reg_rdata_o = (sel == SEL_SEM) ? sem_rdata : cfg_rdata;

  // R2
  open_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fen |-> acc_grant_o);
  // R5
  held_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fen && mutex && acc_cid_i != owner && acc_cid_i != scid) |-> !acc_grant_o);
  // R3
  static_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cid_i == scid) |-> acc_grant_o);
endmodule

// File: tb/test_comp_access_filter.sv
module test_comp_access_filter;
  localparam int ID_W = 3;
  // kind 0 wr cfg, 1 wr sem, 2 grant check (id=cid), 3 read (id[0]=addr)
  localparam int NVEC = 36;
  localparam logic [68:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 32'h0028_0023, 32'h0},          // cfg: on, sem on, scid 2, wl {3,5}
    {2'd3, 3'd0, 32'h0, 32'h0028_0023},          // R10
    {2'd2, 3'd2, 32'h0, 32'h1},                  // R3
    {2'd2, 3'd3, 32'h0, 32'h1},                  // R4
    {2'd2, 3'd5, 32'h0, 32'h1},                  // R4
    {2'd2, 3'd4, 32'h0, 32'h0},                  // R6
    {2'd1, 3'd3, 32'h1, 32'h0},                  // acquire by 3
    {2'd3, 3'd1, 32'h0, 32'h31},                 // R7
    {2'd2, 3'd3, 32'h0, 32'h1},                  // R5 owner
    {2'd2, 3'd5, 32'h0, 32'h0},                  // R5 other
    {2'd2, 3'd2, 32'h0, 32'h1},                  // R3 static during hold
    {2'd1, 3'd5, 32'h1, 32'h0},                  // acquire while held
    {2'd3, 3'd1, 32'h0, 32'h31},                 // R8
    {2'd1, 3'd5, 32'h0, 32'h0},                  // foreign release
    {2'd3, 3'd1, 32'h0, 32'h31},                 // R9
    {2'd1, 3'd3, 32'h0, 32'h0},                  // owner release
    {2'd3, 3'd1, 32'h0, 32'h0},                  // R9
    {2'd2, 3'd5, 32'h0, 32'h1},                  // R4 after release
    {2'd1, 3'd4, 32'h1, 32'h0},                  // non-listed acquire
    {2'd3, 3'd1, 32'h0, 32'h0},                  // R8
    {2'd1, 3'd5, 32'h1, 32'h0},                  // acquire by 5
    {2'd3, 3'd1, 32'h0, 32'h51},                 // R7
    {2'd2, 3'd3, 32'h0, 32'h0},                  // R5
    {2'd0, 3'd0, 32'h0028_0022, 32'h0},          // filter off
    {2'd2, 3'd4, 32'h0, 32'h1},                  // R2
    {2'd2, 3'd3, 32'h0, 32'h1},                  // R2
    {2'd1, 3'd5, 32'h0, 32'h0},                  // release by 5
    {2'd0, 3'd0, 32'h0028_0021, 32'h0},          // sem disabled
    {2'd2, 3'd3, 32'h0, 32'h0},                  // R6
    {2'd2, 3'd2, 32'h0, 32'h1},                  // R3
    {2'd1, 3'd3, 32'h1, 32'h0},                  // acquire with sem off
    {2'd3, 3'd1, 32'h0, 32'h0},                  // R8
    {2'd0, 3'd0, 32'hFFFF_FFFF, 32'h0},
    {2'd3, 3'd0, 32'h0, 32'h00FF_0073},          // R10
    {2'd2, 3'd6, 32'h0, 32'h1},                  // R3 scid 7? no: wl all, mutex free -> R4
    {2'd2, 3'd7, 32'h0, 32'h1}                   // R3
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            reg_we_i = 1'b0;
  logic            reg_addr_i = 1'b0;
  logic [31:0]     reg_wdata_i = '0;
  logic [ID_W-1:0] reg_wid_i = '0;
  logic [31:0]     reg_rdata_o;
  logic [ID_W-1:0] acc_cid_i = '0;
  logic            acc_grant_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  comp_access_filter i_comp_access_filter (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_wid_i,
    .reg_rdata_o, .acc_cid_i, .acc_grant_o
  );

  task automatic wr(input logic a, input logic [31:0] d, input logic [ID_W-1:0] id);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_wid_i = id;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic chk_grant(input logic [ID_W-1:0] cid, input logic exp, input string req);
    acc_cid_i = cid; #1;
    checks++;
    if (acc_grant_o !== exp) begin
      errors++;
      $display("FAIL %s grant cid %0d: actual %b expected %b", req, cid, acc_grant_o, exp);
    end
  endtask

  task automatic chk_read(input logic a, input logic [31:0] exp, input string req);
    reg_addr_i = a; #1;
    checks++;
    if (reg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: actual %h expected %h", req, a, reg_rdata_o, exp);
    end
  endtask

  initial begin
    #3;
    // R1 reset state
    chk_read(1'b0, 32'h0, "R1");
    chk_read(1'b1, 32'h0, "R1");
    for (int c = 0; c < 8; c++) chk_grant(ID_W'(c), 1'b1, "R1");
    @(negedge clk_i); rst_ni = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0]  kind;
      logic [2:0]  id;
      logic [31:0] d, e;
      {kind, id, d, e} = VEC[k];
      case (kind)
        2'd0: wr(1'b0, d, id);
        2'd1: wr(1'b1, d, id);
        2'd2: chk_grant(id, e[0], "R2-R6 vector");
        default: chk_read(id[0], e, "R7-R10 vector");
      endcase
    end

    // R11: write lands at the edge, not before
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 32'h0000_0001; reg_wid_i = '0;
    chk_grant(3'd4, 1'b1, "R11 before edge");
    @(negedge clk_i);
    reg_we_i = 1'b0;
    chk_grant(3'd4, 1'b0, "R11 after edge");
    chk_grant(3'd0, 1'b1, "R11 same-cycle cid change");

    // R1 asynchronous reset clears a held semaphore
    wr(1'b0, 32'h0001_0003, '0);
    wr(1'b1, 32'h1, 3'd0);
    chk_read(1'b1, 32'h1, "R7");
    #2 rst_ni = 1'b0; #1;
    chk_read(1'b1, 32'h0, "R1");
    chk_read(1'b0, 32'h0, "R1");
    chk_grant(3'd6, 1'b1, "R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule